// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block moves 36-bit words from one clock domain to another through a 64-entry store. A producer writes on the write clock and a consumer reads on the read clock. The two clocks may run at unrelated rates or may be the same clock. Each side has an enable and an active-low select, and a word moves on a rising edge only when both are asserted. The write side reports full and almost-full. The read side reports empty and almost-empty and returns data through a registered output. All four flags are active low.

A single threshold input sets both "almost" levels. The threshold is captured while reset is held and is ignored afterwards. Almost-empty compares the number of stored words against it, and almost-full compares the number of free slots against it. The pointers cross between the domains as Gray code through two-stage synchronizers. Because of this, a change made on one side takes two local clock edges to show in the other side's flags. Reset is synchronous and active low. It is held across several edges of both clocks.

Top module: `dual_clock_fifo`

## Requirements
- R1: While reset is held, full_n, afull_n, empty_n and aempty_n are all 0 and rd_data is 0.
- R2: After reset is released, full_n stays 0 through the first write-clock edge and becomes 1 after the second write-clock edge.
- R3: A word is accepted only on a rising edge where the side's enable is 1 and its select is 0. Any other combination leaves the FIFO contents and rd_data unchanged.
- R4: Words are read out in the order they were written, with their values intact.
- R5: With a single shared clock, a write into an empty FIFO on edge k leaves empty_n at 0 after edge k+1 and sets it to 1 after edge k+2.
- R6: While full_n is 0, a write attempt stores nothing. After 64 writes and a blocked extra write, exactly the 64 words are read back and the FIFO is then empty.
- R7: While empty_n is 0, a read attempt leaves rd_data unchanged.
- R8: Once settled, aempty_n is 0 exactly when the stored-word count is less than or equal to the threshold.
- R9: Once settled, afull_n is 0 exactly when the free-slot count (64 minus stored) is less than or equal to the threshold. afull_n is also 0 whenever full_n is 0.
- R10: The threshold is sampled only during reset. Changing it afterwards has no effect on either almost flag.
- R11: With independent write and read clocks of different periods, a long stream with irregular gaps on both sides arrives complete and in order.
- R12: rd_data changes only on a read-clock edge that accepts a read. It holds its value before that edge and whenever no read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Synchronous active-low reset, held across edges of both clocks |
| thresh | input | 6 | Almost-flag threshold, captured during reset |
| wr_en | input | 1 | Write enable, active high |
| wr_cs_n | input | 1 | Write select, active low |
| wr_data | input | 36 | Word to store |
| full_n | output | 1 | Full flag, low when full or not yet ready |
| afull_n | output | 1 | Almost-full flag, low when free slots are at or below the threshold |
| rd_en | input | 1 | Read enable, active high |
| rd_cs_n | input | 1 | Read select, active low |
| rd_data | output | 36 | Registered read word |
| empty_n | output | 1 | Empty flag, low when nothing is stored |
| aempty_n | output | 1 | Almost-empty flag, low when stored words are at or below the threshold |

## Verification
The hardest states to reach from the ports are the exact edge on which a flag releases across the synchronizers, and a write attempted against a completely full store. The bench reaches both by running the two sides on one common clock, which makes the edge count deterministic. It then fills and drains one word at a time, letting the flags settle and checking them arithmetically at every occupancy from 0 to 64, for thresholds of 0, 7 and 63. A final phase switches the read side to an unrelated clock and streams several hundred words with irregular gaps on both sides.

// File: rtl/dcf_pkg.sv
// Package dcf_pkg
// Shared defaults and Gray-code helpers for the dual-clock FIFO.
// Assumes pointer widths never exceed 32 bits.
package dcf_pkg;
    localparam int unsigned DATA_W_DEF = 36;
    localparam int unsigned ADDR_W_DEF = 6;

    // Binary to reflected Gray code.
    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code back to binary.
    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction
endpackage

// File: rtl/dcf_sync.sv
// Module dcf_sync
// Two-stage synchronizer for a Gray-coded pointer entering a new clock domain.
// Assumes at most one bit of d changes between source edges.
module dcf_sync #(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Capture the foreign value and pass it through a second stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dcf_mem.sv
// Module dcf_mem
// Storage array with a write port on wclk and a registered read port on rclk.
// Assumes the control logic never writes and reads the same slot at once.
module dcf_mem #(
    parameter int unsigned DW = 36,
    parameter int unsigned AW = 6
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    // Store an accepted word.
    always_ff @(posedge wclk) begin
        if (we) store[waddr] <= wdata;
    end

    // Load the output register on an accepted read; clear it on reset.
    always_ff @(posedge rclk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= store[raddr];
    end
endmodule

// File: rtl/dcf_wr_side.sv
// Module dcf_wr_side
// Write-domain pointer, full and almost-full logic.
// Assumes rq_gray is the read pointer already synchronized into wclk.
// Full is held low for two edges after reset is released.
module dcf_wr_side #(
    parameter int unsigned AW = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_cs_n,
    input  logic [AW-1:0] thresh,
    input  logic [AW:0] rq_gray,
    output logic [AW:0] wptr,
    output logic [AW:0] wgray,
    output logic        wr_go,
    output logic        full_n,
    output logic        afull_n
);
    localparam int unsigned PW    = AW + 1;
    localparam int unsigned DEPTH = 1 << AW;

    logic [1:0]    wake;
    logic [AW-1:0] thr_q;
    logic [PW-1:0] wnext, rbin, used, free_cnt;

    // Next pointer value and occupancy as seen from the write side.
    always_comb begin
        wnext    = wptr + PW'(1);
        rbin     = PW'(dcf_pkg::from_gray(32'(rq_gray)));
        used     = wptr - rbin;
        free_cnt = PW'(DEPTH) - used;
        full_n   = wake[1] & (used != PW'(DEPTH));
        afull_n  = wake[1] & (free_cnt > PW'(thr_q));
        wr_go    = wr_en & ~wr_cs_n & full_n;
    end

    // Advance the pointer, run the start-up delay and capture the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            wgray <= '0;
            wake  <= '0;
            thr_q <= thresh;
        end else begin
            wake <= {wake[0], 1'b1};
            if (wr_go) begin
                wptr  <= wnext;
                wgray <= PW'(dcf_pkg::to_gray(32'(wnext)));
            end
        end
    end
endmodule

// File: rtl/dcf_rd_side.sv
// Module dcf_rd_side
// Read-domain pointer, empty and almost-empty logic.
// Assumes wq_gray is the write pointer already synchronized into rclk.
module dcf_rd_side #(
    parameter int unsigned AW = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_en,
    input  logic        rd_cs_n,
    input  logic [AW-1:0] thresh,
    input  logic [AW:0] wq_gray,
    output logic [AW:0] rptr,
    output logic [AW:0] rgray,
    output logic        rd_go,
    output logic        empty_n,
    output logic        aempty_n
);
    localparam int unsigned PW = AW + 1;

    logic [AW-1:0] thr_q;
    logic [PW-1:0] rnext, wbin, stored;

    // Occupancy as seen from the read side.
    always_comb begin
        rnext    = rptr + PW'(1);
        wbin     = PW'(dcf_pkg::from_gray(32'(wq_gray)));
        stored   = wbin - rptr;
        empty_n  = (stored != '0);
        aempty_n = (stored > PW'(thr_q));
        rd_go    = rd_en & ~rd_cs_n & empty_n;
    end

    // Advance the pointer and capture the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr  <= '0;
            rgray <= '0;
            thr_q <= thresh;
        end else if (rd_go) begin
            rptr  <= rnext;
            rgray <= PW'(dcf_pkg::to_gray(32'(rnext)));
        end
    end
endmodule

// File: rtl/dual_clock_fifo.sv
// Module dual_clock_fifo
// One-way FIFO from the wclk domain to the rclk domain with active-low
// full, almost-full, empty and almost-empty flags. One threshold, taken
// during reset, sets both almost levels. Assumes rst_n is held for several
// edges of both clocks.
module dual_clock_fifo #(
    parameter int unsigned DW = dcf_pkg::DATA_W_DEF,
    parameter int unsigned AW = dcf_pkg::ADDR_W_DEF
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic [AW-1:0] thresh,
    input  logic          wr_en,
    input  logic          wr_cs_n,
    input  logic [DW-1:0] wr_data,
    output logic          full_n,
    output logic          afull_n,
    input  logic          rd_en,
    input  logic          rd_cs_n,
    output logic [DW-1:0] rd_data,
    output logic          empty_n,
    output logic          aempty_n
);
    localparam int unsigned PW = AW + 1;

    logic [PW-1:0] wptr_bin, wptr_gray, rptr_bin, rptr_gray;
    logic [PW-1:0] wq_gray, rq_gray;
    logic          wr_go, rd_go;

    dcf_wr_side #(.AW(AW)) u_wr (
        .clk(wclk), .rst_n(rst_n), .wr_en(wr_en), .wr_cs_n(wr_cs_n),
        .thresh(thresh), .rq_gray(rq_gray), .wptr(wptr_bin),
        .wgray(wptr_gray), .wr_go(wr_go), .full_n(full_n), .afull_n(afull_n)
    );

    dcf_rd_side #(.AW(AW)) u_rd (
        .clk(rclk), .rst_n(rst_n), .rd_en(rd_en), .rd_cs_n(rd_cs_n),
        .thresh(thresh), .wq_gray(wq_gray), .rptr(rptr_bin),
        .rgray(rptr_gray), .rd_go(rd_go), .empty_n(empty_n), .aempty_n(aempty_n)
    );

    dcf_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rst_n), .d(wptr_gray), .q(wq_gray));
    dcf_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(rst_n), .d(rptr_gray), .q(rq_gray));

    dcf_mem #(.DW(DW), .AW(AW)) u_mem (
        .wclk(wclk), .we(wr_go), .waddr(wptr_bin[AW-1:0]), .wdata(wr_data),
        .rclk(rclk), .rst_n(rst_n), .re(rd_go), .raddr(rptr_bin[AW-1:0]),
        .rdata(rd_data)
    );
endmodule

// File: rtl/dual_clock_fifo_chk.sv
// Module dual_clock_fifo_chk
// Property checker attached to dual_clock_fifo through bind.
module dual_clock_fifo_chk #(
    parameter int unsigned DW = 36,
    parameter int unsigned AW = 6
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          wr_cs_n,
    input logic          rd_en,
    input logic          rd_cs_n,
    input logic          full_n,
    input logic          afull_n,
    input logic          empty_n,
    input logic          aempty_n,
    input logic [DW-1:0] rd_data,
    input logic [AW:0]   wptr_bin,
    input logic [AW:0]   rptr_bin
);
    p_no_overflow_r6: assert property (@(posedge wclk) disable iff (!rst_n)
        (!full_n && wr_en && !wr_cs_n) |=> $stable(wptr_bin));

    p_no_underflow_r7: assert property (@(posedge rclk) disable iff (!rst_n)
        (!empty_n && rd_en && !rd_cs_n) |=> $stable(rd_data));

    p_write_gate_r3: assert property (@(posedge wclk) disable iff (!rst_n)
        (wr_cs_n || !wr_en) |=> $stable(wptr_bin));

    p_read_gate_r3: assert property (@(posedge rclk) disable iff (!rst_n)
        (rd_cs_n || !rd_en) |=> $stable(rptr_bin));

    p_rdata_hold_r12: assert property (@(posedge rclk) disable iff (!rst_n)
        (rd_cs_n || !rd_en) |=> $stable(rd_data));

    p_empty_in_almost_r8: assert property (@(posedge rclk) disable iff (!rst_n)
        !empty_n |-> !aempty_n);

    p_full_in_almost_r9: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |-> !afull_n);
endmodule

bind dual_clock_fifo dual_clock_fifo_chk #(.DW(DW), .AW(AW)) u_chk (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en(wr_en), .wr_cs_n(wr_cs_n),
    .rd_en(rd_en), .rd_cs_n(rd_cs_n), .full_n(full_n), .afull_n(afull_n),
    .empty_n(empty_n), .aempty_n(aempty_n), .rd_data(rd_data),
    .wptr_bin(wptr_bin), .rptr_bin(rptr_bin)
);

// File: tb/dual_clock_fifo_bench.sv
`timescale 1ns/1ps
module dual_clock_fifo_bench;
    localparam int DW = 36;
    localparam int AW = 6;
    localparam int DEPTH = 64;

    logic wclk = 1'b0, aclk = 1'b0, sel_async = 1'b0;
    logic rclk;
    logic rst_n = 1'b0;
    logic [AW-1:0] thresh = '0;
    logic wr_en = 1'b0, wr_cs_n = 1'b0, rd_en = 1'b0, rd_cs_n = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic full_n, afull_n, empty_n, aempty_n;
    logic [DW-1:0] rd_data;

    int tests = 0, fails = 0;
    bit done = 0;

    always #5 wclk = ~wclk;
    always #6.5 aclk = ~aclk;
    assign rclk = sel_async ? aclk : wclk;

    dual_clock_fifo #(.DW(DW), .AW(AW)) u_dual_clock_fifo (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .thresh(thresh),
        .wr_en(wr_en), .wr_cs_n(wr_cs_n), .wr_data(wr_data),
        .full_n(full_n), .afull_n(afull_n), .rd_en(rd_en), .rd_cs_n(rd_cs_n),
        .rd_data(rd_data), .empty_n(empty_n), .aempty_n(aempty_n)
    );

    function automatic logic [DW-1:0] pat(input int i, input int salt);
        logic [31:0] lo;
        lo = 32'(i) * 32'h0100_0193 + 32'(salt) * 32'h9E37_79B1 + 32'h5A5A_0F0F;
        return {4'(i) ^ 4'(salt), lo};
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge wclk);
        @(negedge wclk);
    endtask

    task automatic settle();
        for (int i = 0; i < 4; i++) tick();
    endtask

    // Check all four flags against an occupancy n and threshold x.
    task automatic chk_flags(input int n, input int x);
        chk("R8 aempty_n", DW'(aempty_n), DW'(n > x));
        chk("R9 afull_n", DW'(afull_n), DW'((DEPTH - n) > x));
        chk("R4 empty_n", DW'(empty_n), DW'(n != 0));
        chk("R6 full_n", DW'(full_n), DW'(n != DEPTH));
    endtask

    task automatic do_reset(input int x, input bit async_mode);
        @(negedge wclk);
        rst_n = 1'b0; wr_en = 0; rd_en = 0; wr_cs_n = 0; rd_cs_n = 0;
        sel_async = async_mode;
        thresh = AW'(x);
        for (int i = 0; i < 8; i++) tick();
        chk("R1 full_n", DW'(full_n), '0);
        chk("R1 afull_n", DW'(afull_n), '0);
        chk("R1 empty_n", DW'(empty_n), '0);
        chk("R1 aempty_n", DW'(aempty_n), '0);
        chk("R1 rd_data", rd_data, '0);
        rst_n = 1'b1;
        thresh = ~AW'(x); // R10: later changes must be ignored
    endtask

    // Sweep one threshold with a common clock.
    task automatic sweep(input int x);
        logic [DW-1:0] prev;
        do_reset(x, 1'b0);
        tick();
        chk("R2 full_n after first edge", DW'(full_n), '0);
        tick();
        chk("R2 full_n after second edge", DW'(full_n), 1);
        if (x == 7) begin
            wr_en = 1; wr_cs_n = 1; wr_data = 36'h123456789;
            tick(); tick();
            wr_en = 0; wr_cs_n = 0;
            tick(); tick();
            settle();
            chk("R3 write gated", DW'(empty_n), '0);
        end
        settle();
        chk_flags(0, x);
        for (int n = 1; n <= DEPTH; n++) begin
            wr_en = 1; wr_data = pat(n - 1, x);
            tick();
            wr_en = 0;
            if (n == 1) begin
                chk("R5 empty_n after edge k", DW'(empty_n), '0);
                tick();
                chk("R5 empty_n after edge k+1", DW'(empty_n), '0);
                tick();
                chk("R5 empty_n after edge k+2", DW'(empty_n), 1);
            end
            settle();
            chk_flags(n, x); // R8 R9 R10
        end
        wr_en = 1; wr_data = 36'hDEAD0BEEF;
        tick();
        wr_en = 0;
        settle();
        chk_flags(DEPTH, x);
        prev = '0;
        for (int k = 1; k <= DEPTH; k++) begin
            if (k == 1) begin
                rd_en = 1; rd_cs_n = 1; tick();
                rd_en = 0; rd_cs_n = 0; tick();
                settle();
                chk("R3 read gated data", rd_data, prev);
                chk("R3 read gated count", DW'(aempty_n), DW'(DEPTH > x));
            end
            rd_en = 1;
            chk("R12 data held before edge", rd_data, prev);
            tick();
            rd_en = 0;
            chk("R4 order", rd_data, pat(k - 1, x));
            prev = rd_data;
            settle();
            chk_flags(DEPTH - k, x);
        end
        chk("R6 extra write dropped", DW'(empty_n), '0);
        rd_en = 1; tick(); rd_en = 0; tick();
        chk("R7 read when empty", rd_data, pat(DEPTH - 1, x));
    endtask

    task automatic stream(input int total);
        do_reset(5, 1'b1);
        settle();
        fork
            begin
                int i = 0;
                int cyc = 0;
                while (i < total) begin
                    @(negedge wclk);
                    wr_en = 0;
                    cyc++;
                    if (full_n && ((cyc * 7 + 3) % 5 != 0)) begin
                        wr_en = 1; wr_data = pat(i, 99); i++;
                    end
                end
                @(negedge wclk);
                wr_en = 0;
            end
            begin
                int j = 0;
                int cyc = 0;
                bit pend = 0;
                while (j < total) begin
                    @(negedge rclk);
                    if (pend) begin
                        chk("R11 async stream", rd_data, pat(j, 99));
                        j++;
                    end
                    rd_en = 0; pend = 0;
                    cyc++;
                    if (j < total && empty_n && (cyc % 3 != 0)) begin
                        rd_en = 1; pend = 1;
                    end
                end
            end
        join
        for (int i = 0; i < 8; i++) @(negedge rclk);
        chk("R11 drained", DW'(empty_n), '0);
    endtask

    initial begin
        sweep(0);
        sweep(7);
        sweep(63);
        stream(400);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1_900_000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule